// File: doc/BRIEF.md
# Power Management Timer and Event Block

This block gathers four wake and service events into one status register, gates them through a matching enable register, and drives a level interrupt toward the system controller. A free-running counter advances on a reference tick enable. Each time its most significant bit changes state, the counter raises its own event. This happens on the half-way crossing and on the full wrap.

Firmware reaches the block through a small register port. A status write clears the bits written as one. An enable write loads the gating mask. A timer read returns the live count, zero-extended to 32 bits. Only the low six address bits take part in decoding, so higher address bits alias.

Top module: `pmt_top`

## Requirements
- R1: The counter is TMR_W bits wide, 24 by default. A read at offset 0x08 returns the count in bits TMR_W-1:0 and zero in all higher bits of the 32-bit word.
- R2: The counter adds one, modulo 2^TMR_W, on each clock edge where `tick` is high. It holds its value when `tick` is low.
- R3: Status bit 0 (timer) is set on every tick that changes counter bit TMR_W-1. This covers the change from 0 to 1 and the change from 1 to 0.
- R4: A one-cycle pulse on `ev_glbl`, `ev_pwr` or `ev_rtc` sets status bit 5, bit 8 or bit 10 respectively. Once set, a status bit stays set until it is cleared.
- R5: A write to offset 0x00 clears each status bit whose data bit is 1 and leaves the others unchanged. A read at offset 0x00 returns status in bits 0, 5, 8 and 10, with every other bit zero.
- R6: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R7: A write to offset 0x02 loads the enable register at bit positions 0, 5, 8 and 10. A read at offset 0x02 returns it, with every other bit zero.
- R8: `sci` is high exactly when, at one of the four positions, both the status bit and the enable bit are set.
- R9: Only `io_addr[5:0]` is decoded. Any higher address bits are ignored.
- R10: A read at any offset other than 0x00, 0x02 and 0x08 returns zero. A write to any such offset, or to 0x08, changes no state.
- R11: A synchronous active-high `rst` clears the counter, the status and the enable register. `sci` is then low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable, one pulse per reference period |
| ev_rtc | input | 1 | Alarm event pulse |
| ev_pwr | input | 1 | Power button event pulse |
| ev_glbl | input | 1 | Global lock release event pulse |
| io_addr | input | 16 | Register address, low six bits decoded |
| io_wr | input | 1 | Write strobe, one cycle |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Read data for `io_addr`, combinational |
| sci | output | 1 | Level interrupt request |

## Verification
A status bit that is missed, cleared when it should not be, or stuck can be seen on `sci` in the cycle after the edge, provided its enable bit is set. It can also be seen on the next status read. A counter that drifts shows up on the first timer read. A wrong toggle detector shows up one tick after the top counter bit crosses. The bench builds the counter narrow so that both crossing directions, and many of them, happen within a short run. Random status clears and enable loads keep checking the masked OR against a model on every cycle. The bench reads back all three offsets through aliased addresses.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int DATA_W  = 16;
    localparam int RD_W    = 32;
    localparam int DEC_W   = 6;

    localparam int POS_TMR  = 0;
    localparam int POS_GLBL = 5;
    localparam int POS_PWR  = 8;
    localparam int POS_RTC  = 10;

    localparam logic [DEC_W-1:0] OFS_STS = 6'h00;
    localparam logic [DEC_W-1:0] OFS_ENA = 6'h02;
    localparam logic [DEC_W-1:0] OFS_TMR = 6'h08;

    typedef struct packed {
        logic rtc;
        logic pwr;
        logic glbl;
        logic tmr;
    } evt_t;

    function automatic logic [DATA_W-1:0] evt_to_word(input evt_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[POS_TMR]  = e.tmr;
        w[POS_GLBL] = e.glbl;
        w[POS_PWR]  = e.pwr;
        w[POS_RTC]  = e.rtc;
        return w;
    endfunction

    function automatic evt_t word_to_evt(input logic [DATA_W-1:0] w);
        evt_t e;
        e.tmr  = w[POS_TMR];
        e.glbl = w[POS_GLBL];
        e.pwr  = w[POS_PWR];
        e.rtc  = w[POS_RTC];
        return e;
    endfunction

endpackage

// File: rtl/pmt_timer.sv
module pmt_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [TMR_W-1:0] count,
    output logic             msb_flip
);
    logic [TMR_W-1:0] count_nx;

    always_comb begin
        count_nx = count + {{(TMR_W-1){1'b0}}, 1'b1};
        msb_flip = tick && (count_nx[TMR_W-1] != count[TMR_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick) begin
            count <= count_nx;
        end
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> count == $past(count) + {{(TMR_W-1){1'b0}}, 1'b1});
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

endmodule

// File: rtl/pmt_events.sv
module pmt_events
    import pmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t set_i,
    input  evt_t clr_i,
    input  logic ena_we,
    input  evt_t ena_d,
    output evt_t sts_o,
    output evt_t ena_o,
    output logic sci
);
    evt_t sts_nx;

    always_comb begin
        sts_nx = evt_t'((sts_o & ~clr_i) | set_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_o <= '0;
            ena_o <= '0;
        end else begin
            sts_o <= sts_nx;
            if (ena_we) begin
                ena_o <= ena_d;
            end
        end
    end

    assign sci = |(sts_o & ena_o);

    assert_set_rtc_R4: assert property (@(posedge clk) disable iff (rst)
        set_i.rtc |=> sts_o.rtc);
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (set_i.pwr && clr_i.pwr) |=> sts_o.pwr);
    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (sts_o.glbl && !clr_i.glbl) |=> sts_o.glbl);
    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_i.tmr && !set_i.tmr) |=> !sts_o.tmr);
    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (sts_o == '0 && ena_o == '0 && !sci));

endmodule

// File: rtl/pmt_regif.sv
module pmt_regif
    import pmt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TMR_W  = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  evt_t              sts,
    input  evt_t              ena,
    input  logic [TMR_W-1:0]  count,
    output evt_t              clr,
    output logic              ena_we,
    output evt_t              ena_d,
    output logic [RD_W-1:0]   rdata
);
    logic [DEC_W-1:0] ofs;

    always_comb begin
        ofs    = addr[DEC_W-1:0];
        clr    = (wr && ofs == OFS_STS) ? word_to_evt(wdata) : '0;
        ena_we = wr && (ofs == OFS_ENA);
        ena_d  = word_to_evt(wdata);
        unique case (ofs)
            OFS_STS: rdata = {{(RD_W-DATA_W){1'b0}}, evt_to_word(sts)};
            OFS_ENA: rdata = {{(RD_W-DATA_W){1'b0}}, evt_to_word(ena)};
            OFS_TMR: rdata = {{(RD_W-TMR_W){1'b0}}, count};
            default: rdata = '0;
        endcase
    end

    always_comb begin
        if (ofs == OFS_TMR) begin
            assert_tmr_upper_zero_R1: assert (rdata[RD_W-1:TMR_W] == '0);
        end
    end

endmodule

// File: rtl/pmt_top.sv
module pmt_top
    import pmt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TMR_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ev_rtc,
    input  logic              ev_pwr,
    input  logic              ev_glbl,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [15:0]       io_wdata,
    output logic [31:0]       io_rdata,
    output logic              sci
);
    logic [TMR_W-1:0] count;
    logic             msb_flip;
    evt_t             set_v, clr_v, ena_d, sts, ena;
    logic             ena_we;

    always_comb begin
        set_v.rtc  = ev_rtc;
        set_v.pwr  = ev_pwr;
        set_v.glbl = ev_glbl;
        set_v.tmr  = msb_flip;
    end

    pmt_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .count    (count),
        .msb_flip (msb_flip)
    );

    pmt_events u_events (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .ena_we (ena_we),
        .ena_d  (ena_d),
        .sts_o  (sts),
        .ena_o  (ena),
        .sci    (sci)
    );

    pmt_regif #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) u_regif (
        .addr   (io_addr),
        .wr     (io_wr),
        .wdata  (io_wdata),
        .sts    (sts),
        .ena    (ena),
        .count  (count),
        .clr    (clr_v),
        .ena_we (ena_we),
        .ena_d  (ena_d),
        .rdata  (io_rdata)
    );

    assert_flip_sets_tmr_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && count[TMR_W-2:0] == '1) |=> sts.tmr);

endmodule

// File: tb/tb_pmt_top.sv
`timescale 1ns/1ps
module tb_pmt_top;
    localparam int W = 8;
    localparam logic [15:0] MASK = 16'h0521;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick, ev_rtc, ev_pwr, ev_glbl, io_wr;
    logic [15:0] io_addr, io_wdata;
    logic [31:0] io_rdata;
    logic        sci;

    int checks = 0;
    int errors = 0;
    int m_cnt;
    logic [15:0] m_sts, m_en;

    always #10 clk = ~clk;

    pmt_top #(.ADDR_W(16), .TMR_W(W)) dut (
        .clk(clk), .rst(rst), .tick(tick), .ev_rtc(ev_rtc), .ev_pwr(ev_pwr),
        .ev_glbl(ev_glbl), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .sci(sci)
    );

    function automatic logic [31:0] exp_read(input logic [15:0] a);
        case (a[5:0])
            6'h00:   return {16'h0, m_sts};
            6'h02:   return {16'h0, m_en};
            6'h08:   return 32'(m_cnt);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [15:0] a);
        case (a[5:0])
            6'h00:   return "R3 R4 R5 R6 R9";
            6'h02:   return "R7 R9";
            6'h08:   return "R1 R2 R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_edge;
        int nc;
        logic flip;
        logic [15:0] s;
        nc = tick ? ((m_cnt + 1) % (1 << W)) : m_cnt;
        flip = tick && (((nc >> (W-1)) & 1) != ((m_cnt >> (W-1)) & 1));
        s = m_sts;
        if (io_wr && io_addr[5:0] == 6'h00) s = s & ~io_wdata;
        if (flip)    s[0]  = 1'b1;
        if (ev_glbl) s[5]  = 1'b1;
        if (ev_pwr)  s[8]  = 1'b1;
        if (ev_rtc)  s[10] = 1'b1;
        m_sts = s & MASK;
        if (io_wr && io_addr[5:0] == 6'h02) m_en = io_wdata & MASK;
        m_cnt = nc;
    endtask

    task automatic step(input logic tk, input logic rtc, input logic pwr, input logic gl,
                        input logic wr, input logic [15:0] a, input logic [15:0] d);
        tick = tk; ev_rtc = rtc; ev_pwr = pwr; ev_glbl = gl;
        io_wr = wr; io_addr = a; io_wdata = d;
        #2;
        check(tag_for(a), io_rdata, exp_read(a));
        check("R8", {31'h0, sci}, {31'h0, |(m_sts & m_en)});
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic peek(input logic [15:0] a, input string req);
        tick = 1'b0; ev_rtc = 1'b0; ev_pwr = 1'b0; ev_glbl = 1'b0; io_wr = 1'b0;
        io_addr = a;
        #2;
        check(req, io_rdata, exp_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; tick = 1'b0; ev_rtc = 1'b0; ev_pwr = 1'b0; ev_glbl = 1'b0;
        io_wr = 1'b0; io_addr = '0; io_wdata = '0;
        m_cnt = 0; m_sts = '0; m_en = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        peek(16'h0000, "R11 status");
        peek(16'h0002, "R11 enable");
        peek(16'h0008, "R11 timer");
        check("R11 sci", {31'h0, sci}, 32'h0);

        // R3 both crossing directions
        for (int i = 0; i < (1 << (W-1)); i++) step(1, 0, 0, 0, 0, 16'h0008, 0);
        peek(16'h0000, "R3 rising crossing");
        check("R3 rising bit", {31'h0, io_rdata[0]}, 32'h1);
        step(0, 0, 0, 0, 1, 16'h0000, 16'h0001);
        peek(16'h0000, "R5 clear timer bit");
        for (int i = 0; i < (1 << (W-1)); i++) step(1, 0, 0, 0, 0, 16'h0008, 0);
        peek(16'h0000, "R3 falling crossing");
        check("R3 falling bit", {31'h0, io_rdata[0]}, 32'h1);

        // R6 set beats clear in the same cycle
        step(0, 1, 0, 0, 0, 16'h0000, 0);
        step(0, 1, 0, 0, 1, 16'h0000, 16'h0400);
        peek(16'h0000, "R6 set wins");
        check("R6 rtc bit", {31'h0, io_rdata[10]}, 32'h1);

        // R5 zero bits leave status alone
        step(0, 0, 1, 1, 0, 16'h0000, 0);
        step(0, 0, 0, 0, 1, 16'h0000, 16'hFADE & ~MASK);
        peek(16'h0000, "R5 zero bits no clear");

        // R9 aliased enable write, R8 interrupt
        step(0, 0, 0, 0, 1, 16'hFFC2, 16'hFFFF);
        peek(16'h0002, "R9 aliased enable");
        check("R8 sci high", {31'h0, sci}, 32'h1);
        step(0, 0, 0, 0, 1, 16'h0000, 16'hFFFF);
        peek(16'h0000, "R5 clear all");
        check("R8 sci low", {31'h0, sci}, 32'h0);

        // R10 writes to timer and unmapped offsets
        step(0, 0, 0, 0, 1, 16'h0008, 16'h1234);
        step(0, 0, 0, 0, 1, 16'h0014, 16'hFFFF);
        peek(16'h0008, "R10 timer write ignored");
        peek(16'h0002, "R10 enable unchanged");
        peek(16'h0014, "R10 unmapped read");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            int pick;
            pick = $urandom_range(0, 4);
            a = 16'($urandom) & 16'hFFC0;
            case (pick)
                0: a = a | 16'h0000;
                1: a = a | 16'h0002;
                2: a = a | 16'h0008;
                default: a = a | 16'($urandom_range(0, 63));
            endcase
            step(($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 15) == 0),
                 ($urandom_range(0, 15) == 0),
                 ($urandom_range(0, 15) == 0),
                 ($urandom_range(0, 7) == 0),
                 a, 16'($urandom));
        end

        // R11 reset mid-run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_sts = '0; m_en = '0;
        peek(16'h0000, "R11 status after reset");
        peek(16'h0008, "R11 timer after reset");
        check("R11 sci after reset", {31'h0, sci}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule